// File: doc/BRIEF.md
# Saturating Vector Negate Unit

This block takes one 32-bit SIMD instruction word at a time and checks it for the fixed bit pattern of a saturating negate. When the pattern matches and the fields are legal, the unit reads one source vector from its internal register file. The source is either one 64-bit double register or a 128-bit quad made of two consecutive double registers. Each signed lane of 8, 16 or 32 bits is negated. A lane holding the most negative value becomes the most positive value of its width. The result is written back to the register file, and a sticky saturation flag records that at least one lane was clamped since the flag was last cleared.

Control is a three-state machine. In IDLE the unit is ready. Accepting a legal negate moves it IDLE→WRITE. Accepting a matching word with illegal fields moves it IDLE→FAULT. A word that does not match keeps it in IDLE. WRITE→IDLE and FAULT→IDLE both happen unconditionally after one cycle. A test port writes and reads single double registers directly, so software or a bench can load operands and inspect results.

Top module: `vneg_unit`

## Requirements
- R1: A word is recognised only when bits 31:23 are all ones, bits 21:20 are 11, bits 17:16 are 00, bits 11:7 are 01111 and bit 4 is 0. Any other word is consumed with no result, no undefined indication and no register or flag change.
- R2: Bits 19:18 choose the lane width: 00 selects 8-bit lanes, 01 selects 16-bit lanes and 10 selects 32-bit lanes. Each result lane is the two's-complement negation of the same source lane.
- R3: A lane equal to the most negative value of its width (0x80, 0x8000, 0x80000000) yields the most positive value of that width (0x7F, 0x7FFF, 0x7FFFFFFF). In that case `res_sat` is high during the result cycle.
- R4: `sat_flag` becomes 1 when an executed instruction saturates any lane. Instructions without saturation leave it set. `sat_clear` clears it. When a clear and a saturating write fall in the same cycle, the set wins.
- R5: Bit 6 selects the vector length. When it is 0, one double register is written and bits 127:64 of `res_data` are zero. When it is 1, the low half goes to the even register n and the high half to register n+1.
- R6: The destination register number is {bit 22, bits 15:12}. The source register number is {bit 5, bits 3:0}.
- R7: A matching word with size 11, or with bit 6 set and an odd destination or source number, gives `undef_insn` high for one cycle. It writes no register and leaves the flag unchanged, and `res_valid` stays low.
- R8: `res_valid` is high for exactly the one cycle after acceptance, and `instr_ready` is low in that cycle. The register write and the flag update become visible together on the following cycle.
- R9: After reset every register reads zero, `sat_flag` is 0, `res_valid` and `undef_insn` are 0, and `instr_ready` is 1.
- R10: The test port writes the addressed double register on a clock edge when `tst_we` is high. `tst_rdata` shows the register at `tst_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit can accept a word (IDLE) |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| res_valid | output | 1 | Result cycle (WRITE) |
| res_data | output | 128 | Negated vector |
| res_sat | output | 1 | Current result saturated at least one lane |
| undef_insn | output | 1 | Illegal field combination (FAULT) |
| sat_flag | output | 1 | Sticky saturation flag |
| tst_we | input | 1 | Test write enable |
| tst_waddr | input | 5 | Test write register number |
| tst_wdata | input | 64 | Test write data |
| tst_raddr | input | 5 | Test read register number |
| tst_rdata | output | 64 | Test read data |

## Verification
The assertions assume `instr_valid` is low while reset is asserted. They also assume test writes never fall in a WRITE cycle, because the instruction write port has priority there. The bench offers a word only at a falling edge while the unit is idle and drops it one cycle later. It uses the test port only between instructions, so each result and each flag update can be sampled at a known cycle. The bench checks both clear-versus-set orderings of the flag.

// File: rtl/vneg_pkg.sv
package vneg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_FAULT = 2'd2
    } vneg_state_e;

    typedef enum logic [1:0] {
        LANE_8   = 2'b00,
        LANE_16  = 2'b01,
        LANE_32  = 2'b10,
        LANE_BAD = 2'b11
    } lane_e;

    localparam int REG_NUM_W = 5;

    typedef struct packed {
        logic                 match;
        logic                 illegal;
        logic                 quad;
        lane_e                size;
        logic [REG_NUM_W-1:0] dst;
        logic [REG_NUM_W-1:0] src;
    } vneg_dec_t;

endpackage

// File: rtl/vneg_decode.sv
module vneg_decode
    import vneg_pkg::*;
(
    input  logic [31:0] word,
    output vneg_dec_t   dec
);
    always_comb begin
        dec.match   = (word[31:23] == 9'h1FF) && (word[21:20] == 2'b11)
                   && (word[17:16] == 2'b00) && (word[11:7] == 5'b01111)
                   && !word[4];
        dec.size    = lane_e'(word[19:18]);
        dec.quad    = word[6];
        dec.dst     = {word[22], word[15:12]};
        dec.src     = {word[5], word[3:0]};
        dec.illegal = dec.match && ((dec.size == LANE_BAD)
                   || (dec.quad && (dec.dst[0] || dec.src[0])));
    end
endmodule

// File: rtl/vneg_lanes.sv
module vneg_lanes
    import vneg_pkg::*;
#(
    parameter int VW = 128
) (
    input  logic [VW-1:0] src,
    input  lane_e         size,
    output logic [VW-1:0] res,
    output logic          sat
);
    localparam int NWIDTH = 3;

    logic [VW-1:0]     res_w [NWIDTH];
    logic [NWIDTH-1:0] sat_w;

    for (genvar w = 0; w < NWIDTH; w++) begin : g_w
        localparam int LW = 8 << w;
        localparam int NL = VW / LW;
        logic [NL-1:0] hit;
        for (genvar i = 0; i < NL; i++) begin : g_l
            logic [LW-1:0] x;
            assign x      = src[i*LW +: LW];
            assign hit[i] = (x == {1'b1, {(LW-1){1'b0}}});
            assign res_w[w][i*LW +: LW] = hit[i] ? {1'b0, {(LW-1){1'b1}}}
                                                 : (LW'(0) - x);
        end
        assign sat_w[w] = |hit;
    end

    always_comb begin
        unique case (size)
            LANE_8:  begin res = res_w[0]; sat = sat_w[0]; end
            LANE_16: begin res = res_w[1]; sat = sat_w[1]; end
            LANE_32: begin res = res_w[2]; sat = sat_w[2]; end
            default: begin res = '0;       sat = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/vneg_regfile.sv
module vneg_regfile #(
    parameter  int DW   = 64,
    parameter  int NREG = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_lo,
    output logic [DW-1:0] rd_hi,
    input  logic          wr_en,
    input  logic          wr_quad,
    input  logic [AW-1:0] wr_idx,
    input  logic [2*DW-1:0] wr_data,
    input  logic          tst_we,
    input  logic [AW-1:0] tst_waddr,
    input  logic [DW-1:0] tst_wdata,
    input  logic [AW-1:0] tst_raddr,
    output logic [DW-1:0] tst_rdata
);
    logic [DW-1:0] regs [NREG];
    logic [AW-1:0] rd_nxt, wr_nxt;

    assign rd_nxt    = rd_idx + AW'(1);
    assign wr_nxt    = wr_idx + AW'(1);
    assign rd_lo     = regs[rd_idx];
    assign rd_hi     = regs[rd_nxt];
    assign tst_rdata = regs[tst_raddr];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (!rst_n) begin
                regs[k] <= '0;
            end else if (wr_en && (AW'(k) == wr_idx)) begin
                regs[k] <= wr_data[DW-1:0];
            end else if (wr_en && wr_quad && (AW'(k) == wr_nxt)) begin
                regs[k] <= wr_data[2*DW-1:DW];
            end else if (tst_we && (AW'(k) == tst_waddr)) begin
                regs[k] <= tst_wdata;
            end
        end
    end
endmodule

// File: rtl/vneg_unit.sv
module vneg_unit
    import vneg_pkg::*;
#(
    parameter  int DW   = 64,
    parameter  int NREG = 32,
    localparam int QW   = 2 * DW,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [31:0]   instr_word,
    output logic          instr_ready,
    input  logic          sat_clear,
    output logic          res_valid,
    output logic [QW-1:0] res_data,
    output logic          res_sat,
    output logic          undef_insn,
    output logic          sat_flag,
    input  logic          tst_we,
    input  logic [AW-1:0] tst_waddr,
    input  logic [DW-1:0] tst_wdata,
    input  logic [AW-1:0] tst_raddr,
    output logic [DW-1:0] tst_rdata
);
    vneg_state_e   state_q, state_d;
    vneg_dec_t     dec;
    logic          accept;
    logic [DW-1:0] rd_lo, rd_hi;
    logic [QW-1:0] src_vec, lane_res, res_q;
    logic          lane_sat, sat_q, quad_q, flag_q;
    logic [AW-1:0] dst_q;

    vneg_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    assign src_vec = {dec.quad ? rd_hi : {DW{1'b0}}, rd_lo};

    vneg_lanes #(.VW(QW)) u_lanes (
        .src  (src_vec),
        .size (dec.size),
        .res  (lane_res),
        .sat  (lane_sat)
    );

    vneg_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (dec.src[AW-1:0]),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .wr_en     (state_q == S_WRITE),
        .wr_quad   (quad_q),
        .wr_idx    (dst_q),
        .wr_data   (res_q),
        .tst_we    (tst_we),
        .tst_waddr (tst_waddr),
        .tst_wdata (tst_wdata),
        .tst_raddr (tst_raddr),
        .tst_rdata (tst_rdata)
    );

    assign accept = instr_valid && (state_q == S_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept && dec.illegal)    state_d = S_FAULT;
                else if (accept && dec.match) state_d = S_WRITE;
            end
            S_WRITE: state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            res_q   <= '0;
            sat_q   <= 1'b0;
            quad_q  <= 1'b0;
            dst_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && dec.match && !dec.illegal) begin
                res_q  <= lane_res;
                sat_q  <= lane_sat;
                quad_q <= dec.quad;
                dst_q  <= dec.dst[AW-1:0];
            end
            if ((state_q == S_WRITE) && sat_q) flag_q <= 1'b1;
            else if (sat_clear)                flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        instr_ready = 1'b0;
        res_valid   = 1'b0;
        undef_insn  = 1'b0;
        unique case (state_q)
            S_IDLE:  instr_ready = 1'b1;
            S_WRITE: res_valid   = 1'b1;
            S_FAULT: undef_insn  = 1'b1;
            default: ;
        endcase
        res_data = res_q;
        res_sat  = res_valid && sat_q;
        sat_flag = flag_q;
    end
endmodule

// File: rtl/vneg_unit_chk.sv
module vneg_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_valid,
    input logic instr_ready,
    input logic sat_clear,
    input logic res_valid,
    input logic res_sat,
    input logic undef_insn,
    input logic sat_flag
);
    AST_RES_XOR_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && undef_insn)); // R7
    AST_RES_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(instr_valid && instr_ready)); // R8
    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_BUSY_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !instr_ready); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag); // R4
    AST_FLAG_FROM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(res_sat)); // R3
    AST_UNDEF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_insn && !sat_flag) |=> !sat_flag); // R7
endmodule

bind vneg_unit vneg_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .sat_clear   (sat_clear),
    .res_valid   (res_valid),
    .res_sat     (res_sat),
    .undef_insn  (undef_insn),
    .sat_flag    (sat_flag)
);

// File: tb/vneg_unit_tb.sv
module vneg_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr_word = '0;
    logic         instr_ready;
    logic         sat_clear = 1'b0;
    logic         res_valid;
    logic [127:0] res_data;
    logic         res_sat;
    logic         undef_insn;
    logic         sat_flag;
    logic         tst_we = 1'b0;
    logic [4:0]   tst_waddr = '0;
    logic [63:0]  tst_wdata = '0;
    logic [4:0]   tst_raddr = '0;
    logic [63:0]  tst_rdata;

    int errors = 0;
    int checks = 0;
    logic [63:0] mdl [32];
    logic        flag_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vneg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .sat_clear(sat_clear), .res_valid(res_valid),
        .res_data(res_data), .res_sat(res_sat), .undef_insn(undef_insn),
        .sat_flag(sat_flag), .tst_we(tst_we), .tst_waddr(tst_waddr),
        .tst_wdata(tst_wdata), .tst_raddr(tst_raddr), .tst_rdata(tst_rdata)
    );

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [1:0] size, input logic q,
                                            input logic [4:0] d, input logic [4:0] m);
        return {9'h1FF, d[4], 2'b11, size, 2'b00, d[3:0], 5'b01111, q, m[4], 1'b0, m[3:0]};
    endfunction

    function automatic void calc(input logic [127:0] s, input int lw,
                                 output logic [127:0] r, output logic st);
        r = '0;
        st = 1'b0;
        for (int i = 0; i < 128 / lw; i++) begin
            logic [31:0] msk, v, o;
            msk = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
            v = 32'(s >> (i * lw)) & msk;
            if (v == (32'd1 << (lw - 1))) begin
                o = (32'd1 << (lw - 1)) - 32'd1;
                st = 1'b1;
            end else begin
                o = (32'd0 - v) & msk;
            end
            r = r | (128'(o) << (i * lw));
        end
    endfunction

    task automatic rd_reg(input logic [4:0] idx, output logic [63:0] val);
        tst_raddr = idx;
        #1;
        val = tst_rdata;
    endtask

    task automatic load(input logic [4:0] idx, input logic [63:0] val);
        @(negedge clk);
        tst_we = 1'b1; tst_waddr = idx; tst_wdata = val;
        @(negedge clk);
        tst_we = 1'b0;
        mdl[idx] = val;
    endtask

    // Legal negate: result cycle, write-back and flag
    task automatic t_negate(input string tag, input logic [1:0] size, input logic q,
                            input logic [4:0] d, input logic [4:0] m, input logic clr);
        logic [127:0] exp_r;
        logic         exp_s;
        logic [63:0]  v;
        calc({q ? mdl[m + 5'd1] : 64'd0, mdl[m]}, 8 << size, exp_r, exp_s);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk_word(size, q, d, m);
        @(negedge clk);
        instr_valid = 1'b0;
        sat_clear   = clr;
        chk({tag, " R8 res_valid"}, 128'(res_valid), 128'd1);
        chk({tag, " R8 ready low"}, 128'(instr_ready), 128'd0);
        chk({tag, " R2 data"}, res_data, exp_r);
        chk({tag, " R3 res_sat"}, 128'(res_sat), 128'(exp_s));
        @(negedge clk);
        sat_clear = 1'b0;
        if (exp_s) flag_m = 1'b1;
        else if (clr) flag_m = 1'b0;
        chk({tag, " R4 flag"}, 128'(sat_flag), 128'(flag_m));
        chk({tag, " R8 valid drop"}, 128'(res_valid), 128'd0);
        mdl[d] = exp_r[63:0];
        if (q) mdl[d + 5'd1] = exp_r[127:64];
        rd_reg(d, v);
        chk({tag, " R5 low reg"}, 128'(v), 128'(mdl[d]));
        rd_reg(d + 5'd1, v);
        chk({tag, " R5 next reg"}, 128'(v), 128'(mdl[d + 5'd1]));
    endtask

    // Word that must not write anything
    task automatic t_reject(input string tag, input logic [31:0] w, input logic exp_undef,
                            input logic [4:0] watch);
        logic [63:0] v;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        chk({tag, " undef"}, 128'(undef_insn), 128'(exp_undef));
        chk({tag, " no result"}, 128'(res_valid), 128'd0);
        @(negedge clk);
        chk({tag, " flag held"}, 128'(sat_flag), 128'(flag_m));
        rd_reg(watch, v);
        chk({tag, " reg held"}, 128'(v), 128'(mdl[watch]));
        chk({tag, " ready"}, 128'(instr_ready), 128'd1);
    endtask

    task automatic t_reset;
        logic [63:0] v;
        chk("R9 ready", 128'(instr_ready), 128'd1);
        chk("R9 valid", 128'(res_valid), 128'd0);
        chk("R9 undef", 128'(undef_insn), 128'd0);
        chk("R9 flag", 128'(sat_flag), 128'd0);
        rd_reg(5'd0, v);  chk("R9 reg0", 128'(v), 128'd0);
        rd_reg(5'd31, v); chk("R9 reg31", 128'(v), 128'd0);
    endtask

    task automatic t_test_port;
        logic [63:0] v;
        load(5'd1, 64'h807F_0100_FF81_40C0);
        rd_reg(5'd1, v);
        chk("R10 readback", 128'(v), 128'h807F_0100_FF81_40C0);
    endtask

    task automatic t_clear;
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        flag_m = 1'b0;
        chk("R4 clear", 128'(sat_flag), 128'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();                                                  // R9
        t_test_port();                                              // R10
        t_negate("R2 R3 8b dbl", 2'b00, 1'b0, 5'd2, 5'd1, 1'b0);    // R5 dbl
        t_clear();                                                  // R4
        load(5'd4, 64'h0001_7FFF_FFFF_1234);
        load(5'd5, 64'h0000_8001_0100_FF00);
        t_negate("R6 16b quad D", 2'b01, 1'b1, 5'd18, 5'd4, 1'b0);
        load(5'd20, 64'h8000_0000_0000_0005);
        load(5'd21, 64'hFFFF_FFFF_7FFF_FFFF);
        t_negate("R6 32b quad M", 2'b10, 1'b1, 5'd6, 5'd20, 1'b0);
        t_negate("R4 sticky", 2'b00, 1'b0, 5'd10, 5'd2, 1'b0);
        load(5'd8, 64'h8000_0001_0000_FFFF);
        t_negate("R4 set wins", 2'b01, 1'b0, 5'd9, 5'd8, 1'b1);
        t_negate("R4 clr in write", 2'b01, 1'b0, 5'd12, 5'd4, 1'b1);
        load(5'd14, 64'h1111_2222_3333_4444);
        t_negate("R3 16b sat", 2'b01, 1'b0, 5'd16, 5'd8, 1'b0);
        t_reject("R7 size11", mk_word(2'b11, 1'b0, 5'd14, 5'd4), 1'b1, 5'd14);
        t_reject("R7 odd quad", mk_word(2'b00, 1'b1, 5'd3, 5'd4), 1'b1, 5'd3);
        t_reject("R7 odd src", mk_word(2'b01, 1'b1, 5'd14, 5'd5), 1'b1, 5'd14);
        t_reject("R1 bit4", mk_word(2'b00, 1'b0, 5'd14, 5'd4) | 32'h10, 1'b0, 5'd14);
        t_reject("R1 op bits", mk_word(2'b00, 1'b0, 5'd14, 5'd4) & ~32'h0010_0000, 1'b0, 5'd14);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule